// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block performs an add, subtract or bitwise logical operation on two 32-bit operands at a selectable operand size of 8, 16 or 32 bits. It drives the masked result combinationally and derives six status flags from it: carry, overflow, sign, zero, auxiliary carry and parity. The flags are captured in a six-bit status register on the clock edge that follows a valid operation.

The same register has a single-bit write port. Software can force any one flag to 0 or 1 in a cycle without disturbing the others. When an operation and a software write arrive in the same cycle, the operation updates every flag except the one being written, and that bit takes the written value.

Top module: `status_flag_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the status register clears to 0 on that edge.
- R2: Operation codes are 0 add, 1 subtract, 2 AND, 3 OR and 4 XOR. Size codes are 0 for 8 bits, 1 for 16 bits, 2 for 32 bits and 3 for 32 bits. `res_out` is the operation result over the selected width, and all bits above that width are zero.
- R3: Carry (status bit 0): for add, it is set when the unsigned sum of the width-masked operands does not fit in the width. For subtract, it is set when masked `a_in` is less than masked `b_in` (a borrow).
- R4: Overflow (status bit 1) is set when the signed result at the selected width is out of range. For add, this means the operand signs are equal and the result sign differs. For subtract, it means the operand signs differ and the result sign differs from that of `a_in`.
- R5: Sign (status bit 2) equals the result bit at position width-1. Zero (status bit 3) is set when the masked result is all zeros.
- R6: Auxiliary carry (status bit 4): for add, it is set when the low nibbles sum past 0xF. For subtract, it is set when the low nibble of `a_in` is below the low nibble of `b_in`.
- R7: Parity (status bit 5) is set when `res_out[7:0]` holds an even number of ones.
- R8: A logical operation clears carry, overflow and auxiliary carry.
- R9: The status register loads the new flags on the edge after `op_valid` is high with a code of 0 to 4. Otherwise it holds. Codes 5 to 7 give `res_out` = 0 and leave the flags unchanged.
- R10: With `fw_en` high, status bit `fw_sel` takes the value of `fw_val` on the next edge and the other bits are unchanged. Values 6 and 7 of `fw_sel` have no effect.
- R11: When a valid operation and a software write occur in the same cycle, the written bit takes `fw_val` and every other bit takes the operation's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Operation select |
| op_size | input | 2 | Operand size select |
| a_in | input | 32 | First operand |
| b_in | input | 32 | Second operand (subtrahend) |
| fw_en | input | 1 | Single-flag write enable |
| fw_sel | input | 3 | Index of the flag to write |
| fw_val | input | 1 | Value to write |
| res_out | output | 32 | Masked result |
| flags_out | output | 6 | Status register: PF, AF, ZF, SF, OF, CF from bit 5 down to bit 0 |

## Verification
Two functions can fall in the same cycle: a flag update caused by an operation, and a software write to a single flag. The bench drives cycles with `op_valid` and `fw_en` both high. In these cycles the write targets a bit whose value from the operation would be the opposite of the written value. The bench judges the result by comparing the whole register with a model in which the write overrides only its own bit. Writes to the unused indices 6 and 7 are also combined with operations, and the bench confirms that the flags from the operation alone appear.

// File: rtl/sfg_pkg.sv
package sfg_pkg;

    localparam int DATA_W  = 32;
    localparam int FLAG_N  = 6;
    localparam int SEL_W   = $clog2(FLAG_N);

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_ALT  = 2'd3
    } size_e;

    // Packed so that cf lands on bit 0 and pf on bit 5
    typedef struct packed {
        logic pf;
        logic af;
        logic zf;
        logic sf;
        logic of;
        logic cf;
    } flags_t;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              cf;
        logic              of;
        logic              af;
    } arith_t;

    function automatic logic [5:0] size_bits(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: size_bits = 6'd8;
            SZ_HALF: size_bits = 6'd16;
            default: size_bits = 6'd32;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: size_mask = 32'h0000_00FF;
            SZ_HALF: size_mask = 32'h0000_FFFF;
            default: size_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic is_legal(input logic [2:0] code);
        is_legal = (code <= 3'd4);
    endfunction

endpackage

// File: rtl/sfg_arith.sv
module sfg_arith
    import sfg_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    input  logic [1:0]        size,
    output arith_t            out
);
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   sum_full;
    logic [DATA_W:0]   cin_at;     // carry entering each bit position
    logic [5:0]        w;

    assign b_eff    = sub ? ~b : b;
    assign sum_full = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
    assign cin_at[0]      = sub;
    assign cin_at[DATA_W] = sum_full[DATA_W];

    genvar k;
    generate
        for (k = 1; k < DATA_W; k++) begin : g_carry
            assign cin_at[k] = a[k] ^ b_eff[k] ^ sum_full[k];
        end
    endgenerate

    assign w = size_bits(size);

    always_comb begin
        out.res = sum_full[DATA_W-1:0] & size_mask(size);
        out.cf  = cin_at[w] ^ sub;
        out.of  = cin_at[w] ^ cin_at[w - 6'd1];
        out.af  = cin_at[4] ^ sub;
    end
endmodule

// File: rtl/sfg_flag_calc.sv
module sfg_flag_calc
    import sfg_pkg::*;
(
    input  logic [2:0]        code,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res,
    output flags_t            flags
);
    arith_t            ar;
    logic [DATA_W-1:0] lg;
    logic [5:0]        w;
    logic              arith_op;

    sfg_arith u_arith (
        .a    (a),
        .b    (b),
        .sub  (code == OP_SUB),
        .size (size),
        .out  (ar)
    );

    assign w        = size_bits(size);
    assign arith_op = (code == OP_ADD) || (code == OP_SUB);

    always_comb begin
        case (code)
            OP_AND:  lg = a & b;
            OP_OR:   lg = a | b;
            OP_XOR:  lg = a ^ b;
            default: lg = '0;
        endcase
    end

    always_comb begin
        if (!is_legal(code))
            res = '0;
        else if (arith_op)
            res = ar.res;
        else
            res = lg & size_mask(size);
    end

    always_comb begin
        flags.cf = arith_op & ar.cf;
        flags.of = arith_op & ar.of;
        flags.af = arith_op & ar.af;
        flags.sf = res[w - 6'd1];
        flags.zf = (res == '0);
        flags.pf = ~^res[7:0];
    end
endmodule

// File: rtl/sfg_flag_reg.sv
module sfg_flag_reg
    import sfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             upd,
    input  flags_t           calc,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic             wr_val,
    output flags_t           q
);
    flags_t d;

    always_comb begin
        d = q;
        if (upd)
            d = calc;
        if (wr_en && (wr_sel < SEL_W'(FLAG_N)))
            d[wr_sel] = wr_val;
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= d;
    end
endmodule

// File: rtl/status_flag_gen.sv
module status_flag_gen
    import sfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [1:0]        op_size,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              fw_en,
    input  logic [SEL_W-1:0]  fw_sel,
    input  logic              fw_val,
    output logic [DATA_W-1:0] res_out,
    output logic [FLAG_N-1:0] flags_out
);
    flags_t calc_flags;
    flags_t reg_q;

    sfg_flag_calc u_calc (
        .code  (op_code),
        .size  (op_size),
        .a     (a_in),
        .b     (b_in),
        .res   (res_out),
        .flags (calc_flags)
    );

    sfg_flag_reg u_reg (
        .clk    (clk),
        .rst    (rst),
        .upd    (op_valid && is_legal(op_code)),
        .calc   (calc_flags),
        .wr_en  (fw_en),
        .wr_sel (fw_sel),
        .wr_val (fw_val),
        .q      (reg_q)
    );

    assign flags_out = reg_q;
endmodule

// File: rtl/status_flag_gen_chk.sv
module status_flag_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic [2:0]  op_code,
    input logic [1:0]  op_size,
    input logic        fw_en,
    input logic [2:0]  fw_sel,
    input logic        fw_val,
    input logic [31:0] res_out,
    input logic [5:0]  flags_out
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (flags_out == 6'd0));

    assert_byte_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (op_size == 2'd0) |-> (res_out[31:8] == 24'd0));

    assert_half_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (op_size == 2'd1) |-> (res_out[31:16] == 16'd0));

    assert_parity_capture_R7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code <= 3'd4 && !fw_en) |=> (flags_out[5] == ~^$past(res_out[7:0])));

    assert_logic_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code >= 3'd2 && op_code <= 3'd4 && !fw_en)
        |=> (flags_out[0] == 1'b0 && flags_out[1] == 1'b0 && flags_out[4] == 1'b0));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!(op_valid && op_code <= 3'd4) && !fw_en) |=> $stable(flags_out));

    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (op_code >= 3'd5) |-> (res_out == 32'd0));

    assert_sw_write_R10: assert property (@(posedge clk) disable iff (rst)
        (fw_en && fw_sel <= 3'd5) |=> (flags_out[$past(fw_sel)] == $past(fw_val)));
endmodule

bind status_flag_gen status_flag_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .op_size   (op_size),
    .fw_en     (fw_en),
    .fw_sel    (fw_sel),
    .fw_val    (fw_val),
    .res_out   (res_out),
    .flags_out (flags_out)
);

// File: tb/status_flag_gen_tb.sv
module status_flag_gen_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [1:0]  op_size = 2'd2;
    logic [31:0] a_in = '0;
    logic [31:0] b_in = '0;
    logic        fw_en = 1'b0;
    logic [2:0]  fw_sel = 3'd0;
    logic        fw_val = 1'b0;
    logic [31:0] res_out;
    logic [5:0]  flags_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [5:0] model_flags = 6'd0;
    logic [5:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    status_flag_gen u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .op_size(op_size), .a_in(a_in), .b_in(b_in), .fw_en(fw_en),
        .fw_sel(fw_sel), .fw_val(fw_val), .res_out(res_out), .flags_out(flags_out)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model written from the requirements
    task automatic model(input logic [2:0] op, input logic [1:0] sz,
                         input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] r, output logic [5:0] f);
        int w;
        longint unsigned am, bm, mk, full;
        logic sa, sb, sr, cf, of, af;
        w  = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        mk = (64'd1 << w) - 64'd1;
        am = {32'd0, a} & mk;
        bm = {32'd0, b} & mk;
        cf = 1'b0; of = 1'b0; af = 1'b0;
        case (op)
            3'd0: begin full = am + bm; cf = (full > mk); af = ({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15; end
            3'd1: begin full = (am - bm) & mk; cf = (am < bm); af = (a[3:0] < b[3:0]); end
            3'd2: full = am & bm;
            3'd3: full = am | bm;
            3'd4: full = am ^ bm;
            default: full = 0;
        endcase
        r  = 32'(full & mk);
        sa = am[w-1]; sb = bm[w-1]; sr = r[w-1];
        if (op == 3'd0) of = (sa == sb) && (sr != sa);
        if (op == 3'd1) of = (sa != sb) && (sr != sa);
        f = {~^r[7:0], af, (r == 32'd0), sr, of, cf};
    endtask

    // Driver: applies one cycle of stimulus, checks the result, queues the expected flags
    task automatic drive(input logic v, input logic [2:0] op, input logic [1:0] sz,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic we, input logic [2:0] ws, input logic wv, input string req);
        logic [31:0] er;
        logic [5:0]  ef;
        @(negedge clk);
        op_valid = v; op_code = op; op_size = sz; a_in = a; b_in = b;
        fw_en = we; fw_sel = ws; fw_val = wv;
        model(op, sz, a, b, er, ef);
        #1;
        check(res_out === er, {req, " result"}, res_out, er);
        if (v && op <= 3'd4) model_flags = ef;
        if (we && ws <= 3'd5) model_flags[ws] = wv;
        exp_q.push_back(model_flags);
        tag_q.push_back(req);
    endtask

    // Monitor: compares the status register one edge after each driven cycle
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [5:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(flags_out === e, {t, " flags"}, {26'd0, flags_out}, {26'd0, e});
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check(flags_out === 6'd0, "R1 reset clear", {26'd0, flags_out}, 32'd0);
        rst = 1'b0;

        // R3 R5 R6 R7: 32-bit add wrapping to zero
        drive(1, 3'd0, 2'd2, 32'hFFFF_FFFF, 32'h1, 0, 0, 0, "R3 add carry 32");
        // R4: signed overflow at 32 bits
        drive(1, 3'd0, 2'd2, 32'h7FFF_FFFF, 32'h1, 0, 0, 0, "R4 add overflow 32");
        // R6: nibble borrow at 8 bits, upper operand bits ignored (R2)
        drive(1, 3'd1, 2'd0, 32'hABCD_EF10, 32'h1234_5601, 0, 0, 0, "R6 sub nibble borrow 8");
        // R3 R5: 16-bit borrow, negative result
        drive(1, 3'd1, 2'd1, 32'h0000_0001, 32'h0000_0002, 0, 0, 0, "R3 sub borrow 16");
        // R4: 8-bit signed overflow on subtract
        drive(1, 3'd1, 2'd0, 32'h0000_0080, 32'h0000_0001, 0, 0, 0, "R4 sub overflow 8");
        // R4: 16-bit add overflow, carry clear
        drive(1, 3'd0, 2'd1, 32'hFFFF_4000, 32'h0000_4000, 0, 0, 0, "R4 add overflow 16");
        // R8: logical ops clear CF OF AF after flags were set
        drive(1, 3'd0, 2'd0, 32'hFF, 32'h81, 0, 0, 0, "R3 add carry 8");
        drive(1, 3'd2, 2'd0, 32'hFFFF_FF0F, 32'h0000_00F3, 0, 0, 0, "R8 and 8");
        drive(1, 3'd3, 2'd1, 32'h1234_8000, 32'h0000_0001, 0, 0, 0, "R8 or 16");
        drive(1, 3'd4, 2'd2, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 0, 0, 0, "R5 xor zero 32");
        // R2: size code 3 acts as 32 bits
        drive(1, 3'd0, 2'd3, 32'h8000_0000, 32'h8000_0000, 0, 0, 0, "R2 size3 as 32");
        // R9: reserved code and idle cycles leave flags unchanged
        drive(1, 3'd6, 2'd2, 32'h1, 32'h1, 0, 0, 0, "R9 reserved code");
        drive(0, 3'd0, 2'd2, 32'hFFFF_FFFF, 32'h1, 0, 0, 0, "R9 idle hold");
        // R10: single-bit writes, unused indices
        drive(0, 3'd0, 2'd2, 32'h0, 32'h0, 1, 3'd5, 1'b0, "R10 clear parity");
        drive(0, 3'd0, 2'd2, 32'h0, 32'h0, 1, 3'd1, 1'b1, "R10 set overflow");
        drive(0, 3'd0, 2'd2, 32'h0, 32'h0, 1, 3'd6, 1'b1, "R10 index 6 ignored");
        drive(0, 3'd0, 2'd2, 32'h0, 32'h0, 1, 3'd7, 1'b0, "R10 index 7 ignored");
        // R11: operation and write in the same cycle
        drive(1, 3'd0, 2'd2, 32'hFFFF_FFFF, 32'h1, 1, 3'd3, 1'b0, "R11 write beats zero");
        drive(1, 3'd2, 2'd0, 32'h0F, 32'hF0, 1, 3'd0, 1'b1, "R11 write beats cleared carry");
        drive(1, 3'd1, 2'd0, 32'h5, 32'h5, 1, 3'd6, 1'b1, "R11 unused index with op");

        lfsr = 32'hACE1_2345;
        for (int i = 0; i < 40; i++) begin
            logic [31:0] ra, rb;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            ra = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            rb = lfsr ^ {lfsr[15:0], lfsr[31:16]};
            drive(1, 3'(i % 5), 2'(i % 4), ra, rb, 0, 0, 0, "R3 R4 R5 R6 R7 mixed");
        end

        drive(0, 3'd0, 2'd2, 32'h0, 32'h0, 0, 0, 0, "R9 final hold");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule